// File: doc/BRIEF.md
# Two-Way Karatsuba Unsigned Multiplier

This block multiplies two unsigned operands with a single level of Karatsuba decomposition and presents the full-width product with no clock. Each operand is cut at its midpoint into an upper and a lower half. Three half-width products are formed: lower times lower, upper times upper, and the product of the two half-sums. The usual fourth partial product is not needed. The middle term is recovered by subtracting the two outer products from the half-sum product. The three terms are then weighted by shifts and added.

The block is meant as a drop-in replacement for a plain multiplier where area and depth matter. The operand width is a parameter and must be even. The default is 8 bits, which gives 4-bit halves. The two outer sub-multipliers are 4×4. The middle one is 5×5, because each half-sum carries one extra bit.

Top module: `kmul_top`

## Requirements
- R1: For every pair of unsigned 8-bit operands `a` and `b`, `d` equals the exact 16-bit product `a*b`.
- R2: Bits [3:0] of `d` equal bits [3:0] of the product of the lower 4-bit halves of `a` and `b`.
- R3: With both operands at their largest value (255), `d` is 65025. In every case the corrected middle term is non-negative and below 2^9.
- R4: If either operand is zero, `d` is zero.
- R5: `a` = 8 and `b` = 10 give `d` = 80.
- R6: If the lower halves (bits [3:0]) of both operands are zero, `d` equals the product of the upper halves shifted left by 8.
- R7: `d` is a pure function of the present `a` and `b`. It follows a change on the inputs within the same half clock period, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| d | output | 16 | Unsigned product of a and b |

## Verification
The hardest case is the largest middle-term correction. Here the half-sum product carries into its top bit, and nearly all of it is cancelled by the two outer products. This only happens when both halves of both operands are large together. The stimulus therefore sweeps every operand pair, so every carry pattern out of the pre-adders meets every borrow pattern of the subtraction. Directed pairs with zero lower halves and the all-ones corner are added on top and checked under their own requirements.

// File: rtl/kmul_pkg.sv
// Package: shared sizing helpers for the Karatsuba multiplier.
// Assumes the operand width is even.
package kmul_pkg;

    // Default operand width of the multiplier.
    localparam int unsigned KMUL_DEFAULT_W = 8;

    // Width of one operand half.
    function automatic int unsigned half_w(input int unsigned w);
        return w / 2;
    endfunction

    // Width of the half-sum product (two (h+1)-bit factors).
    function automatic int unsigned mid_w(input int unsigned w);
        return 2 * (w / 2) + 2;
    endfunction

endpackage

// File: rtl/kmul_array_mult.sv
// Module: kmul_array_mult
// Plain unsigned array multiplier. It forms one shifted row per bit of y
// and sums the rows. Purely combinational; assumes AW, BW >= 1.
module kmul_array_mult #(
    parameter int unsigned AW = 4,
    parameter int unsigned BW = 4
) (
    input  logic [AW-1:0]    x,
    input  logic [BW-1:0]    y,
    output logic [AW+BW-1:0] p
);
    localparam int unsigned PW = AW + BW;

    logic [PW-1:0] rows [BW];

    // One gated, shifted copy of x per multiplier bit.
    for (genvar i = 0; i < BW; i++) begin : g_row
        assign rows[i] = y[i] ? (PW'(x) << i) : '0;
    end

    // Accumulate all rows into the product.
    always_comb begin
        p = '0;
        for (int i = 0; i < BW; i++) begin
            p = p + rows[i];
        end
    end
endmodule

// File: rtl/kmul_presplit.sv
// Module: kmul_presplit
// Cuts one operand into upper and lower halves and forms their sum, which
// is one bit wider than a half. Assumes W is even.
module kmul_presplit #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   opnd,
    output logic [W/2-1:0] lo_half,
    output logic [W/2-1:0] hi_half,
    output logic [W/2:0]   half_sum
);
    localparam int unsigned H = W / 2;

    // Split the operand at its midpoint.
    assign lo_half = opnd[H-1:0];
    assign hi_half = opnd[W-1:H];

    // Pre-adder: zero-extend both halves so the carry is kept.
    assign half_sum = {1'b0, lo_half} + {1'b0, hi_half};
endmodule

// File: rtl/kmul_merge.sv
// Module: kmul_merge
// Removes the outer products from the half-sum product to get the cross
// term, then weights the three terms by shifts and adds them. Assumes the
// half-sum product is at least lo_prod + hi_prod, which always holds.
module kmul_merge #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]     lo_prod,
    input  logic [W-1:0]     hi_prod,
    input  logic [W+1:0]     sum_prod,
    output logic [W+1:0]     cross_term,
    output logic [2*W-1:0]   prod
);
    localparam int unsigned H  = W / 2;
    localparam int unsigned CW = W + 2;
    localparam int unsigned PW = 2 * W;

    // Middle-term correction in unsigned arithmetic; never borrows.
    assign cross_term = sum_prod - CW'(lo_prod) - CW'(hi_prod);

    // Final shifted addition of the three weighted terms.
    assign prod = (PW'(hi_prod) << W) + (PW'(cross_term) << H) + PW'(lo_prod);
endmodule

// File: rtl/kmul_top.sv
// Module: kmul_top
// One-level Karatsuba unsigned multiplier: three half-width products
// replace four. Purely combinational, no clock or reset.
// Assumes WIDTH is even and at least 2.
module kmul_top #(
    parameter int unsigned WIDTH = kmul_pkg::KMUL_DEFAULT_W
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] d
);
    localparam int unsigned H  = kmul_pkg::half_w(WIDTH);
    localparam int unsigned MW = kmul_pkg::mid_w(WIDTH);

    logic [H-1:0]       a_lo, a_hi, b_lo, b_hi;
    logic [H:0]         a_sum, b_sum;
    logic [WIDTH-1:0]   lo_prod, hi_prod;
    logic [MW-1:0]      sum_prod;
    logic [MW-1:0]      cross_term;

    // Operand splitting and pre-adders.
    kmul_presplit #(.W(WIDTH)) u_split_a (
        .opnd(a), .lo_half(a_lo), .hi_half(a_hi), .half_sum(a_sum)
    );
    kmul_presplit #(.W(WIDTH)) u_split_b (
        .opnd(b), .lo_half(b_lo), .hi_half(b_hi), .half_sum(b_sum)
    );

    // The three half-width products.
    kmul_array_mult #(.AW(H), .BW(H)) u_mul_lo (
        .x(a_lo), .y(b_lo), .p(lo_prod)
    );
    kmul_array_mult #(.AW(H), .BW(H)) u_mul_hi (
        .x(a_hi), .y(b_hi), .p(hi_prod)
    );
    kmul_array_mult #(.AW(H + 1), .BW(H + 1)) u_mul_sum (
        .x(a_sum), .y(b_sum), .p(sum_prod)
    );

    // Middle-term correction and final recombination.
    kmul_merge #(.W(WIDTH)) u_merge (
        .lo_prod(lo_prod), .hi_prod(hi_prod), .sum_prod(sum_prod),
        .cross_term(cross_term), .prod(d)
    );
endmodule

// File: rtl/kmul_top_chk.sv
// Module: kmul_top_chk
// Checker for kmul_top. Because the block has no clock, it uses immediate
// assertions on settled combinational values.
module kmul_top_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic [2*WIDTH-1:0] d,
    input logic [WIDTH-1:0]   lo_prod,
    input logic [WIDTH-1:0]   hi_prod,
    input logic [WIDTH+1:0]   sum_prod,
    input logic [WIDTH+1:0]   cross_term
);
    localparam int unsigned H = WIDTH / 2;

    // Check the product and the intermediate terms whenever inputs settle.
    always_comb begin
        AST_PRODUCT_EXACT: assert (32'(d) == 32'(a) * 32'(b)); // R1
        AST_LOW_DIGIT: assert (d[H-1:0] == lo_prod[H-1:0]); // R2
        AST_CROSS_NONNEG: assert (32'(sum_prod) >= 32'(lo_prod) + 32'(hi_prod)); // R3
        AST_CROSS_BOUND: assert (32'(cross_term) < (32'd1 << (2 * H + 1))); // R3
        AST_ZERO_OPERAND: assert (!(a == '0 || b == '0) || d == '0); // R4
        AST_HIGH_ONLY: assert (!(a[H-1:0] == '0 && b[H-1:0] == '0) || d == ({{WIDTH{1'b0}}, hi_prod} << WIDTH)); // R6
    end
endmodule

bind kmul_top kmul_top_chk #(.WIDTH(WIDTH)) u_kmul_chk (
    .a(a), .b(b), .d(d), .lo_prod(lo_prod), .hi_prod(hi_prod),
    .sum_prod(sum_prod), .cross_term(cross_term)
);

// File: tb/test_kmul_top.sv
// Bench for kmul_top: a behavioural reference (integer product, queued per
// cycle) compared with d on every clock, away from the driving edge.
module test_kmul_top;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   a = '0;
    logic [W-1:0]   b = '0;
    logic [2*W-1:0] d;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    int  exp_q[$];

    kmul_top #(.WIDTH(W)) i_kmul_top (.a(a), .b(b), .d(d));

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Compare one observed value against its expectation.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    // Apply one pair at the rising edge; check d at the falling edge.
    task automatic apply(input int x, input int y, input string req);
        @(posedge clk);
        a <= W'(x);
        b <= W'(y);
        exp_q.push_back(x * y);
        @(negedge clk);
        check(req, int'(d), exp_q.pop_front());
    endtask

    // Main stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check("R4 reset-state", int'(d), 0);
        apply(8, 10, "R5");
        apply(255, 255, "R3");
        apply(0, 200, "R4");
        apply(173, 0, "R4");
        apply(16 * 9, 16 * 14, "R6");
        apply(16 * 15, 16 * 15, "R6");
        // Low-digit check: lower halves 7 and 9 give 63, low digit 15.
        @(posedge clk);
        a <= 8'h37;
        b <= 8'hA9;
        @(negedge clk);
        check("R2", int'(d[3:0]), (7 * 9) % 16);
        // Same-half-cycle response with no clock edge in between.
        @(posedge clk);
        a <= 8'd200;
        b <= 8'd3;
        #3;
        check("R7", int'(d), 600);
        a = 8'd99;
        #2;
        check("R7", int'(d), 297);
        // Exhaustive sweep for the exact product.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                apply(x, y, "R1");
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule